// File: doc/BRIEF.md
# Five-Port Mesh Packet Router

This block is the switch at one node of a 4x4 two-dimensional mesh network-on-chip. It has five ports: local, north, east, south and west. Every port moves one 32-bit flit per cycle. A packet is either a 2-flit control packet or an 18-flit data packet. The router reads the destination and the packet kind from the head flit. It sends the packet on X first and then on Y, and it delivers the packet to the local port when the destination coordinates equal the node's own.

Switching is virtual cut-through. A head flit may leave before its tail has arrived, but only when the next hop shows go, which means that hop can hold a whole data packet. Each link carries a level-sensitive stop signal back towards the sender, and the sender holds its flits while stop is high. Each output is granted to one input at a time and stays granted until that packet's tail flit has left. Requests that compete for the same output are served in round-robin order.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and on the first cycle after it, every `out_valid` bit and every `in_stop` bit is 0.
- R2: Head flit fields: bits [1:0] hold the destination X and bits [3:2] the destination Y. A packet whose X differs from the node's X leaves on east (port 2) when the destination X is larger and on west (port 4) when it is smaller. Only when X matches does Y decide: north (port 1) when the destination Y is larger, south (port 3) when it is smaller. Port 0 is local.
- R3: A packet whose X and Y both equal the node's coordinates leaves on the local port (0).
- R4: Head bit 4 selects the length: 0 means 2 flits and 1 means 18 flits. Exactly that many flits leave on the chosen output, unchanged and in arrival order.
- R5: A head flit leaves one cycle after it is accepted, if the output is free and not stopped, without waiting for the rest of its packet.
- R6: No flit leaves an output while that output's `out_stop` is high. A held packet resumes where it stopped once `out_stop` falls.
- R7: `in_stop` of a port is high exactly while its buffer holds more than 18 flits (depth 36). At go, the buffer therefore always has room for a whole data packet.
- R8: Once an output starts a packet, it carries only flits of that packet until the tail flit has left.
- R9: When several inputs wait for the same free output, the grant goes to the first waiting input after the previous winner, in increasing port order with wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | One bit per input port: a flit is present |
| in_flit | input | 160 | Input flits, port p in bits [32p+31:32p] |
| in_stop | output | 5 | Stop level returned to each upstream sender |
| out_valid | output | 5 | One bit per output port: a flit is driven |
| out_flit | output | 160 | Output flits, port p in bits [32p+31:32p] |
| out_stop | input | 5 | Stop level from each downstream receiver |

## Verification
Internal state is visible at the ports after a short delay. A wrong head pointer or count in an input buffer changes the flit contents or moves the cycle at which `in_stop` rises. A grant that is lost or duplicated shows up on the outputs within one packet time, as interleaved or missing flits. A wrong remaining-flit counter frees an output too early or too late, so the next packet arrives cut short or with extra flits. The stimulus holds outputs stopped so that competing packets queue up. This exposes the arbitration order and the buffer threshold, which plain unloaded traffic never reaches.

// File: rtl/noc_rtr_pkg.sv
package noc_rtr_pkg;
    localparam int NP       = 5;
    localparam int FW       = 32;
    localparam int IW       = $clog2(NP);
    localparam int CW       = 2;
    localparam int CTRL_LEN = 2;
    localparam int DATA_LEN = 18;
    localparam int RW       = $clog2(DATA_LEN + 1);
    localparam int FLD_X    = 0;
    localparam int FLD_Y    = FLD_X + CW;
    localparam int FLD_KIND = FLD_Y + CW;

    localparam logic [IW-1:0] P_LOCAL = IW'(0);
    localparam logic [IW-1:0] P_NORTH = IW'(1);
    localparam logic [IW-1:0] P_EAST  = IW'(2);
    localparam logic [IW-1:0] P_SOUTH = IW'(3);
    localparam logic [IW-1:0] P_WEST  = IW'(4);

    function automatic logic [RW-1:0] pkt_len(input logic kind);
        return kind ? RW'(DATA_LEN) : RW'(CTRL_LEN);
    endfunction
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 36,
    parameter int ROOM  = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         stop
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   wp;
        logic [AW-1:0]   rp;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNTW'(DEPTH));
    assign stop  = (st_q.cnt > CNTW'(DEPTH - ROOM));
    assign dout  = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wp] <= din;
    end
endmodule

// File: rtl/rtr_route.sv
module rtr_route
    import noc_rtr_pkg::*;
#(
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic [FW-1:0] head,
    output logic [IW-1:0] port
);
    logic [CW-1:0] dx, dy;

    always_comb begin
        dx = head[FLD_X +: CW];
        dy = head[FLD_Y +: CW];
        if      (dx > CW'(MY_X)) port = P_EAST;
        else if (dx < CW'(MY_X)) port = P_WEST;
        else if (dy > CW'(MY_Y)) port = P_NORTH;
        else if (dy < CW'(MY_Y)) port = P_SOUTH;
        else                     port = P_LOCAL;
    end
endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
    parameter int N  = 5,
    parameter int XW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [XW-1:0] last,
    output logic          any,
    output logic [XW-1:0] win
);
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last) + k) % N;
            if (!any && req[cand]) begin
                any = 1'b1;
                win = XW'(cand);
            end
        end
    end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import noc_rtr_pkg::*;
#(
    parameter int MY_X      = 1,
    parameter int MY_Y      = 1,
    parameter int BUF_DEPTH = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NP-1:0]    in_valid,
    input  logic [NP*FW-1:0] in_flit,
    output logic [NP-1:0]    in_stop,
    output logic [NP-1:0]    out_valid,
    output logic [NP*FW-1:0] out_flit,
    input  logic [NP-1:0]    out_stop
);
    typedef struct packed {
        logic [NP-1:0]         busy;
        logic [NP-1:0][IW-1:0] owner;
        logic [NP-1:0][IW-1:0] last;
        logic [NP-1:0][RW-1:0] rem;
    } xbar_st_t;

    xbar_st_t st_d, st_q;

    logic [FW-1:0] head    [NP];
    logic [IW-1:0] dest    [NP];
    logic [IW-1:0] win     [NP];
    logic [IW-1:0] sel     [NP];
    logic [NP-1:0] any;
    logic [NP-1:0] empty, full, pop, held;
    logic [NP-1:0] req     [NP];
    logic [NP-1:0] busy_w;
    logic [NP*IW-1:0] owner_w;

    for (genvar p = 0; p < NP; p++) begin : g_in
        rtr_fifo #(.W(FW), .DEPTH(BUF_DEPTH), .ROOM(DATA_LEN)) u_buf (
            .clk  (clk),
            .rst  (rst),
            .push (in_valid[p]),
            .din  (in_flit[p*FW +: FW]),
            .pop  (pop[p]),
            .dout (head[p]),
            .empty(empty[p]),
            .full (full[p]),
            .stop (in_stop[p])
        );
        rtr_route #(.MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .head(head[p]),
            .port(dest[p])
        );
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            held[i] = 1'b0;
            for (int o = 0; o < NP; o++)
                if (st_q.busy[o] && st_q.owner[o] == IW'(i)) held[i] = 1'b1;
        end
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                req[o][i] = !empty[i] && !held[i] && dest[i] == IW'(o);
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        rtr_rr_arb #(.N(NP), .XW(IW)) u_arb (
            .req (req[o]),
            .last(st_q.last[o]),
            .any (any[o]),
            .win (win[o])
        );
        assign busy_w[o]             = st_q.busy[o];
        assign owner_w[o*IW +: IW]   = st_q.owner[o];
    end

    always_comb begin
        st_d      = st_q;
        pop       = '0;
        out_valid = '0;
        out_flit  = '0;
        for (int o = 0; o < NP; o++) begin
            logic grant, send;
            grant  = !st_q.busy[o] && any[o] && !out_stop[o];
            sel[o] = st_q.busy[o] ? st_q.owner[o] : win[o];
            send   = grant || (st_q.busy[o] && !empty[sel[o]] && !out_stop[o]);
            out_valid[o]            = send;
            out_flit[o*FW +: FW]    = head[sel[o]];
            if (send) pop[sel[o]]   = 1'b1;
            if (grant) begin
                st_d.busy[o]  = 1'b1;
                st_d.owner[o] = win[o];
                st_d.last[o]  = win[o];
                st_d.rem[o]   = pkt_len(head[win[o]][FLD_KIND]) - 1'b1;
            end else if (send) begin
                st_d.rem[o] = st_q.rem[o] - 1'b1;
                if (st_q.rem[o] == RW'(1)) st_d.busy[o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/router_chk.sv
module router_chk
    import noc_rtr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NP-1:0]    in_valid,
    input logic [NP-1:0]    in_stop,
    input logic [NP-1:0]    out_valid,
    input logic [NP*FW-1:0] out_flit,
    input logic [NP-1:0]    out_stop,
    input logic [NP-1:0]    busy,
    input logic [NP*IW-1:0] owner,
    input logic [NP-1:0]    full
);
    logic rst_seen_q;
    logic [RW-1:0] left_q [NP];

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            // R1
            reset_quiet_chk: assert (out_valid == '0 && in_stop == '0);
        end
    end

    for (genvar o = 0; o < NP; o++) begin : g_o
        always_ff @(posedge clk) begin
            if (rst) left_q[o] <= '0;
            else if (out_valid[o])
                left_q[o] <= (left_q[o] == '0)
                    ? pkt_len(out_flit[o*FW + FLD_KIND]) - 1'b1
                    : left_q[o] - 1'b1;
        end

        // R4
        pkt_len_chk: assert property (@(posedge clk) disable iff (rst)
            left_q[o] != '0 |-> busy[o]);

        // R8
        hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
            (left_q[o] != '0 && busy[o]) |=> (left_q[o] == '0 || $stable(owner[o*IW +: IW])));

        // R6
        stall_chk: assert property (@(posedge clk) disable iff (rst)
            out_stop[o] |=> $stable(busy[o]));
    end

    for (genvar i = 0; i < NP; i++) begin : g_i
        // R7
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid[i] |-> !full[i]);
    end
endmodule

bind mesh_router router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_stop  (in_stop),
    .out_valid(out_valid),
    .out_flit (out_flit),
    .out_stop (out_stop),
    .busy     (busy_w),
    .owner    (owner_w),
    .full     (full)
);

// File: tb/test_mesh_router.sv
`timescale 1ns/1ps
module test_mesh_router;
    localparam int NP = 5;
    localparam int FW = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    in_valid = '0;
    logic [NP*FW-1:0] in_flit  = '0;
    logic [NP-1:0]    in_stop;
    logic [NP-1:0]    out_valid;
    logic [NP*FW-1:0] out_flit;
    logic [NP-1:0]    out_stop = '0;

    int checks = 0;
    int errors = 0;
    int rx_cnt [NP];
    logic [31:0] rx_mem [NP][128];

    always #2.5 clk = ~clk;

    mesh_router #(.MY_X(1), .MY_Y(1), .BUF_DEPTH(36)) i_mesh_router (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
        .in_stop(in_stop), .out_valid(out_valid), .out_flit(out_flit),
        .out_stop(out_stop)
    );

    initial for (int o = 0; o < NP; o++) rx_cnt[o] = 0;

    always @(negedge clk) begin
        if (!rst)
            for (int o = 0; o < NP; o++)
                if (out_valid[o]) begin
                    if (rx_cnt[o] < 128) rx_mem[o][rx_cnt[o]] = out_flit[o*FW +: FW];
                    rx_cnt[o] = rx_cnt[o] + 1;
                end
    end

    // {in_port[2:0], dx[1:0], dy[1:0], kind, out_port[2:0]}
    localparam logic [10:0] VEC [6] = '{
        {3'd4, 2'd1, 2'd1, 1'b0, 3'd0},
        {3'd0, 2'd3, 2'd1, 1'b1, 3'd2},
        {3'd1, 2'd0, 2'd2, 1'b0, 3'd4},
        {3'd3, 2'd1, 2'd3, 1'b1, 3'd1},
        {3'd2, 2'd1, 2'd0, 1'b0, 3'd3},
        {3'd0, 2'd2, 2'd3, 1'b0, 3'd2}
    };

    function automatic logic [31:0] mk_flit(int id, int k, int dx, int dy, bit kind);
        if (k == 0) return {id[7:0], 16'h0, 3'b0, kind, dy[1:0], dx[1:0]};
        return {id[7:0], 8'h00, k[7:0], 8'h00};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input int port, input int dx, input int dy, input bit kind, input int id);
        int len;
        len = kind ? 18 : 2;
        for (int k = 0; k < len; k++) begin
            while (in_stop[port]) cyc(1);
            in_valid[port] = 1'b1;
            in_flit[port*FW +: FW] = mk_flit(id, k, dx, dy, kind);
            cyc(1);
            in_valid[port] = 1'b0;
        end
    endtask

    // compare flits of one packet at rx_mem[o][base..]
    task automatic check_pkt(input int o, input int base, input int dx, input int dy,
                             input bit kind, input int id, input string req);
        int len, bad, badk;
        len = kind ? 18 : 2;
        bad = 0;
        badk = 0;
        for (int k = 0; k < len; k++)
            if (bad == 0 && rx_mem[o][base+k] !== mk_flit(id, k, dx, dy, kind)) begin
                bad = 1;
                badk = k;
            end
        check(bad == 0, req, int'(rx_mem[o][base+badk]), int'(mk_flit(id, badk, dx, dy, kind)));
    endtask

    initial begin
        int base [NP];
        cyc(4);
        // R1: outputs quiet during reset
        check(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        cyc(1);
        check(out_valid == '0 && in_stop == '0, "R1 after reset", int'({in_stop, out_valid}), 0);

        // routing table walk: R2 R3 R4
        for (int v = 0; v < 6; v++) begin
            int ip, dx, dy, op, len, stray;
            bit kind;
            ip = int'(VEC[v][10:8]); dx = int'(VEC[v][7:6]); dy = int'(VEC[v][5:4]);
            kind = VEC[v][3]; op = int'(VEC[v][2:0]);
            len = kind ? 18 : 2;
            for (int o = 0; o < NP; o++) base[o] = rx_cnt[o];
            send_pkt(ip, dx, dy, kind, 10 + v);
            cyc(25);
            stray = 0;
            for (int o = 0; o < NP; o++) if (o != op) stray += rx_cnt[o] - base[o];
            check(rx_cnt[op] - base[op] == len, (op == 0) ? "R3 local count" : "R2 route count",
                  rx_cnt[op] - base[op], len);
            check(stray == 0, "R2 no flits on other ports", stray, 0);
            check_pkt(op, base[op], dx, dy, kind, 10 + v, "R4 flit contents");
        end

        // R5: cut-through, head out before tail in
        base[3] = rx_cnt[3];
        fork
            send_pkt(0, 1, 0, 1'b1, 30);
            begin
                cyc(6);
                check(rx_cnt[3] - base[3] > 0 && rx_cnt[3] - base[3] < 18,
                      "R5 early forwarding", rx_cnt[3] - base[3], 5);
            end
        join
        cyc(25);
        check(rx_cnt[3] - base[3] == 18, "R5 full packet", rx_cnt[3] - base[3], 18);

        // R6: stalled output
        out_stop[2] = 1'b1;
        base[2] = rx_cnt[2];
        send_pkt(4, 3, 0, 1'b0, 40);
        cyc(10);
        check(rx_cnt[2] == base[2], "R6 no flit while stopped", rx_cnt[2] - base[2], 0);
        out_stop[2] = 1'b0;
        cyc(6);
        check(rx_cnt[2] - base[2] == 2, "R6 resume", rx_cnt[2] - base[2], 2);
        check_pkt(2, base[2], 3, 0, 1'b0, 40, "R6 contents");

        // R7: buffer threshold with a stopped output
        out_stop[0] = 1'b1;
        base[0] = rx_cnt[0];
        fork
            begin
                send_pkt(1, 1, 1, 1'b1, 50);
                send_pkt(1, 1, 1, 1'b1, 51);
            end
            begin
                cyc(18);
                check(in_stop[1] == 1'b0, "R7 go at 18 flits", int'(in_stop[1]), 0);
                cyc(6);
                check(in_stop[1] == 1'b1, "R7 stop above 18 flits", int'(in_stop[1]), 1);
                out_stop[0] = 1'b0;
                cyc(3);
                check(in_stop[1] == 1'b0, "R7 go after drain", int'(in_stop[1]), 0);
            end
        join
        cyc(30);
        check(rx_cnt[0] - base[0] == 36, "R7 all flits delivered", rx_cnt[0] - base[0], 36);
        check_pkt(0, base[0], 1, 1, 1'b1, 50, "R7 first packet");
        check_pkt(0, base[0] + 18, 1, 1, 1'b1, 51, "R7 second packet");

        // R8 R9: three contenders for local, previous winner was input 1
        out_stop[0] = 1'b1;
        base[0] = rx_cnt[0];
        fork
            send_pkt(4, 1, 1, 1'b0, 62);
            send_pkt(3, 1, 1, 1'b0, 61);
            send_pkt(2, 1, 1, 1'b1, 60);
        join
        cyc(3);
        out_stop[0] = 1'b0;
        cyc(40);
        check(rx_cnt[0] - base[0] == 22, "R8 total flits", rx_cnt[0] - base[0], 22);
        check_pkt(0, base[0],      1, 1, 1'b1, 60, "R9 first winner east");
        check_pkt(0, base[0] + 18, 1, 1, 1'b0, 61, "R9 second winner south");
        check_pkt(0, base[0] + 20, 1, 1, 1'b0, 62, "R8 third packet intact");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule